// File: doc/BRIEF.md
# Doorbell Request Dispatcher

The dispatcher sits behind a storage host controller's register file. It holds three sources of work: a link-control command register, a task-management doorbell and a transfer doorbell. It picks one piece of work at a time and presents it on an issue port. Each issue carries the request kind, the slot index and the byte address of that slot's descriptor. The descriptor address is computed from a 64-bit list base (a high and a low 32-bit word) plus the slot index times the entry size of that list. Downstream logic fetches the descriptors, moves the data and reports completion with per-slot pulses.

A slot counts as new work when its doorbell bit differs from the dispatcher's tracked copy. Loading a slot into the issue register sets its tracked bit, so a slot is handed out once per ring. A completion clears the tracked bit, clears the doorbell and raises a sticky interrupt status bit that software clears by writing one. A command is retired when the issue port accepts it: the command register returns to zero and the command-complete status bit is set. A transfer completion follows the host-side rule for that list. The doorbell keeps only the slots that are still tracked, so a slot rung but not yet picked up is dropped at that moment.

Top module: `doorbell_dispatcher`

## Requirements
- R1: After reset, iss_valid is 0 and irq_stat, uic_cmd, task_db and xfer_db are all zero.
- R2: Work is pending when uic_cmd is non-zero, or when task_db or xfer_db has a bit set that is not tracked. With iss_valid low and work pending, the issue register loads on the next clock edge.
- R3: Priority is fixed. A command (iss_kind 0) goes before a task request (iss_kind 1), and a task request goes before a transfer request (iss_kind 2).
- R4: Within the task or transfer list, the slot issued is the lowest-numbered doorbell bit that is set and not tracked. A multi-bit ring is therefore issued in ascending slot order.
- R5: iss_addr is the 64-bit value {base_hi, base_lo} plus iss_slot times the entry size of that list, with the carry running from the low word into the high word. A command issues slot 0 and address 0.
- R6: When a command issue is accepted (iss_valid and iss_ready high), uic_cmd becomes 0 and irq_stat bit 0 is set on the same edge, unless cmd_we writes a new command on that edge.
- R7: A task completion pulse on a tracked slot clears only that bit of task_db and sets irq_stat bit 1.
- R8: A transfer completion pulse on a tracked slot sets irq_stat bit 2. On the same edge, xfer_db becomes the tracked set minus the completed slots, plus any ring on that cycle. Any bit that was rung but not yet picked up is discarded.
- R9: A tracked slot is not issued again while it is outstanding, even if it is rung again. After its completion, a new ring issues it again.
- R10: Only one request is held at a time. While iss_valid is high and iss_ready is low, iss_kind, iss_slot and iss_addr stay unchanged, even if higher-priority work arrives. After an accept, iss_valid is low for at least one cycle.
- R11: irq_stat bits are cleared by writing 1 to the matching irq_clr bit. A status set on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | CMD_W | Command value to write |
| task_ring | input | TASK_SLOTS | Bits to set in the task doorbell |
| xfer_ring | input | XFER_SLOTS | Bits to set in the transfer doorbell |
| task_base_lo | input | 32 | Task list base, low word |
| task_base_hi | input | 32 | Task list base, high word |
| xfer_base_lo | input | 32 | Transfer list base, low word |
| xfer_base_hi | input | 32 | Transfer list base, high word |
| task_done | input | TASK_SLOTS | Per-slot task completion pulses |
| xfer_done | input | XFER_SLOTS | Per-slot transfer completion pulses |
| irq_clr | input | 3 | Write-one-to-clear for irq_stat |
| iss_ready | input | 1 | Downstream accepts the held issue |
| iss_valid | output | 1 | An issue is held |
| iss_kind | output | 2 | 0 command, 1 task, 2 transfer |
| iss_slot | output | clog2(XFER_SLOTS) | Slot index of the issue |
| iss_addr | output | 64 | Descriptor byte address |
| uic_cmd | output | CMD_W | Current command register |
| task_db | output | TASK_SLOTS | Current task doorbell |
| xfer_db | output | XFER_SLOTS | Current transfer doorbell |
| irq_stat | output | 3 | Bit 0 command done, bit 1 task done, bit 2 transfer done |

## Verification
The hardest case to reach is the loss of a transfer slot that was rung but never picked up, because the dispatcher normally grabs a fresh ring two edges after it lands. The bench first issues and accepts one transfer. It then writes a command and holds that command issue with iss_ready low, so the issue register stays busy. During that window it rings a second transfer slot and pulses the first slot's completion. It then checks that the doorbell becomes empty and that nothing is issued after the command is released. Sweeps over every ring pattern of a small configuration check the ascending order and the address arithmetic, including the carry into the high base word.

// File: rtl/dbd_pkg.sv
package dbd_pkg;

   typedef enum logic [1:0] {
      KIND_UIC  = 2'd0,
      KIND_TASK = 2'd1,
      KIND_XFER = 2'd2
   } dbd_kind_e;

   localparam int IRQ_UIC  = 0;
   localparam int IRQ_TASK = 1;
   localparam int IRQ_XFER = 2;

endpackage

// File: rtl/dbd_lsb_pick.sv
module dbd_lsb_pick #(
   parameter int N  = 32,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

   assign found = |vec;

endmodule

// File: rtl/dbd_slot_ctl.sv
module dbd_slot_ctl #(
   parameter int N           = 32,
   parameter bit TRACK_CLEAR = 1'b0,
   parameter int IW          = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  ring,
   input  logic [N-1:0]  done,
   input  logic          take,
   input  logic [IW-1:0] take_idx,
   output logic [N-1:0]  db,
   output logic [N-1:0]  trk,
   output logic [N-1:0]  fresh,
   output logic          done_hit
);

   logic [N-1:0] done_eff;
   logic [N-1:0] take_bit;
   logic [N-1:0] trk_n;
   logic [N-1:0] db_n;

   assign done_eff = done & trk;
   assign take_bit = take ? (N'(1) << take_idx) : '0;
   assign trk_n    = (trk | take_bit) & ~done_eff;
   assign fresh    = db ^ trk;
   assign done_hit = |done_eff;

   generate
      if (TRACK_CLEAR) begin : g_keep_tracked
         // completion keeps only the slots still tracked
         assign db_n = (done_hit ? (db & trk_n) : db) | ring;
      end else begin : g_clear_slot
         assign db_n = (db & ~done_eff) | ring;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         db  <= '0;
         trk <= '0;
      end else begin
         db  <= db_n;
         trk <= trk_n;
      end
   end

endmodule

// File: rtl/doorbell_dispatcher.sv
module doorbell_dispatcher
   import dbd_pkg::*;
#(
   parameter int TASK_SLOTS  = 8,
   parameter int XFER_SLOTS  = 32,
   parameter int TASK_ENTRY  = 80,
   parameter int XFER_ENTRY  = 32,
   parameter int CMD_W       = 8,
   localparam int TIW        = (TASK_SLOTS > 1) ? $clog2(TASK_SLOTS) : 1,
   localparam int SW         = (XFER_SLOTS > 1) ? $clog2(XFER_SLOTS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_we,
   input  logic [CMD_W-1:0]      cmd_wdata,
   input  logic [TASK_SLOTS-1:0] task_ring,
   input  logic [XFER_SLOTS-1:0] xfer_ring,
   input  logic [31:0]           task_base_lo,
   input  logic [31:0]           task_base_hi,
   input  logic [31:0]           xfer_base_lo,
   input  logic [31:0]           xfer_base_hi,
   input  logic [TASK_SLOTS-1:0] task_done,
   input  logic [XFER_SLOTS-1:0] xfer_done,
   input  logic [2:0]            irq_clr,
   input  logic                  iss_ready,
   output logic                  iss_valid,
   output logic [1:0]            iss_kind,
   output logic [SW-1:0]         iss_slot,
   output logic [63:0]           iss_addr,
   output logic [CMD_W-1:0]      uic_cmd,
   output logic [TASK_SLOTS-1:0] task_db,
   output logic [XFER_SLOTS-1:0] xfer_db,
   output logic [2:0]            irq_stat
);

   generate
      if (XFER_SLOTS < 1 || XFER_SLOTS > 32) begin : g_bad_xfer
         $error("XFER_SLOTS must lie in 1..32");
      end
      if (TASK_SLOTS < 1 || TASK_SLOTS > XFER_SLOTS) begin : g_bad_task
         $error("TASK_SLOTS must lie in 1..XFER_SLOTS");
      end
      if (TASK_ENTRY < 1 || XFER_ENTRY < 1) begin : g_bad_entry
         $error("entry sizes must be positive");
      end
      if (CMD_W < 1 || CMD_W > 32) begin : g_bad_cmd
         $error("CMD_W must lie in 1..32");
      end
   endgenerate

   logic [TASK_SLOTS-1:0] t_fresh, t_trk;
   logic [XFER_SLOTS-1:0] x_fresh, x_trk;
   logic                  t_found, x_found, t_hit, x_hit;
   logic [TIW-1:0]        t_idx;
   logic [SW-1:0]         x_idx;

   logic [CMD_W-1:0]      cmd_q;
   logic [2:0]            irq_q;
   logic                  valid_q;
   dbd_kind_e             kind_q;
   logic [SW-1:0]         slot_q;
   logic [63:0]           addr_q;

   logic pend_uic, load, take_task, take_xfer, accept, uic_acc;
   logic [63:0] t_addr, x_addr;

   assign pend_uic  = |cmd_q;
   assign load      = !valid_q && (pend_uic || t_found || x_found);
   assign take_task = load && !pend_uic && t_found;
   assign take_xfer = load && !pend_uic && !t_found && x_found;
   assign accept    = valid_q && iss_ready;
   assign uic_acc   = accept && (kind_q == KIND_UIC);

   dbd_slot_ctl #(.N(TASK_SLOTS), .TRACK_CLEAR(1'b0)) u_task (
      .clk(clk), .rst_n(rst_n), .ring(task_ring), .done(task_done),
      .take(take_task), .take_idx(t_idx), .db(task_db), .trk(t_trk),
      .fresh(t_fresh), .done_hit(t_hit)
   );

   dbd_slot_ctl #(.N(XFER_SLOTS), .TRACK_CLEAR(1'b1)) u_xfer (
      .clk(clk), .rst_n(rst_n), .ring(xfer_ring), .done(xfer_done),
      .take(take_xfer), .take_idx(x_idx), .db(xfer_db), .trk(x_trk),
      .fresh(x_fresh), .done_hit(x_hit)
   );

   dbd_lsb_pick #(.N(TASK_SLOTS), .IW(TIW)) u_tpick (
      .vec(t_fresh), .found(t_found), .idx(t_idx)
   );

   dbd_lsb_pick #(.N(XFER_SLOTS), .IW(SW)) u_xpick (
      .vec(x_fresh), .found(x_found), .idx(x_idx)
   );

   assign t_addr = {task_base_hi, task_base_lo} + 64'(t_idx) * 64'(TASK_ENTRY);
   assign x_addr = {xfer_base_hi, xfer_base_lo} + 64'(x_idx) * 64'(XFER_ENTRY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         irq_q   <= '0;
         valid_q <= 1'b0;
         kind_q  <= KIND_UIC;
         slot_q  <= '0;
         addr_q  <= '0;
      end else begin
         if (cmd_we)       cmd_q <= cmd_wdata;
         else if (uic_acc) cmd_q <= '0;

         irq_q <= (irq_q & ~irq_clr) | {x_hit, t_hit, uic_acc};

         if (accept) begin
            valid_q <= 1'b0;
         end else if (load) begin
            valid_q <= 1'b1;
            if (pend_uic) begin
               kind_q <= KIND_UIC;
               slot_q <= '0;
               addr_q <= '0;
            end else if (t_found) begin
               kind_q <= KIND_TASK;
               slot_q <= SW'(t_idx);
               addr_q <= t_addr;
            end else begin
               kind_q <= KIND_XFER;
               slot_q <= x_idx;
               addr_q <= x_addr;
            end
         end
      end
   end

   assign iss_valid = valid_q;
   assign iss_kind  = kind_q;
   assign iss_slot  = slot_q;
   assign iss_addr  = addr_q;
   assign uic_cmd   = cmd_q;
   assign irq_stat  = irq_q;

endmodule

// File: rtl/dbd_chk.sv
module dbd_chk #(
   parameter int TS    = 8,
   parameter int XS    = 32,
   parameter int SW    = 5,
   parameter int CMD_W = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          iss_valid,
   input logic          iss_ready,
   input logic [1:0]    iss_kind,
   input logic [SW-1:0] iss_slot,
   input logic [63:0]   iss_addr,
   input logic          cmd_we,
   input logic [CMD_W-1:0] uic_cmd,
   input logic [2:0]    irq_stat,
   input logic [TS-1:0] task_done,
   input logic [XS-1:0] xfer_done,
   input logic [TS-1:0] t_trk,
   input logic [XS-1:0] x_trk
);

   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && !iss_ready |=> iss_valid && $stable(iss_kind)
                                  && $stable(iss_slot) && $stable(iss_addr));

   // R6
   uic_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && iss_ready && iss_kind == 2'd0 && !cmd_we
      |=> uic_cmd == '0 && irq_stat[0]);

   // R3
   uic_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_valid && uic_cmd != '0 |=> iss_valid && iss_kind == 2'd0);

   // R9
   one_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({t_trk, x_trk} & ~$past({t_trk, x_trk})) <= 1);

   // R7
   task_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (task_done & t_trk) != '0 |=> irq_stat[1]);

   // R8
   xfer_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done & x_trk) != '0 |=> irq_stat[2]);

endmodule

bind doorbell_dispatcher dbd_chk #(
   .TS(TASK_SLOTS), .XS(XFER_SLOTS), .SW(SW), .CMD_W(CMD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
   .iss_kind(iss_kind), .iss_slot(iss_slot), .iss_addr(iss_addr),
   .cmd_we(cmd_we), .uic_cmd(uic_cmd), .irq_stat(irq_stat),
   .task_done(task_done), .xfer_done(xfer_done), .t_trk(t_trk), .x_trk(x_trk)
);

// File: tb/tb_doorbell_dispatcher.sv
`timescale 1ns/1ps
module tb_doorbell_dispatcher;

   localparam int TS = 4;
   localparam int XS = 8;
   localparam int TE = 80;
   localparam int XE = 32;
   localparam int SW = 3;
   localparam logic [1:0] K_UIC = 2'd0, K_TASK = 2'd1, K_XFER = 2'd2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_we = 1'b0;
   logic [7:0] cmd_wdata = '0;
   logic [TS-1:0] task_ring = '0, task_done = '0;
   logic [XS-1:0] xfer_ring = '0, xfer_done = '0;
   logic [31:0] task_base_lo = '0, task_base_hi = '0;
   logic [31:0] xfer_base_lo = '0, xfer_base_hi = '0;
   logic [2:0] irq_clr = '0;
   logic iss_ready = 1'b0;
   logic iss_valid;
   logic [1:0] iss_kind;
   logic [SW-1:0] iss_slot;
   logic [63:0] iss_addr;
   logic [7:0] uic_cmd;
   logic [TS-1:0] task_db;
   logic [XS-1:0] xfer_db;
   logic [2:0] irq_stat;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   doorbell_dispatcher #(
      .TASK_SLOTS(TS), .XFER_SLOTS(XS), .TASK_ENTRY(TE), .XFER_ENTRY(XE), .CMD_W(8)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .task_ring(task_ring), .xfer_ring(xfer_ring),
      .task_base_lo(task_base_lo), .task_base_hi(task_base_hi),
      .xfer_base_lo(xfer_base_lo), .xfer_base_hi(xfer_base_hi),
      .task_done(task_done), .xfer_done(xfer_done), .irq_clr(irq_clr),
      .iss_ready(iss_ready), .iss_valid(iss_valid), .iss_kind(iss_kind),
      .iss_slot(iss_slot), .iss_addr(iss_addr), .uic_cmd(uic_cmd),
      .task_db(task_db), .xfer_db(xfer_db), .irq_stat(irq_stat)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic expect_issue(input logic [1:0] kind, input int slot,
                               input logic [63:0] addr, input string req);
      int n = 0;
      tick();
      while (!iss_valid && n < 12) begin
         tick();
         n++;
      end
      chk(iss_valid, {req, " R2 issue appears"}, 64'(iss_valid), 64'd1);
      chk(iss_kind == kind, {req, " R3 kind"}, 64'(iss_kind), 64'(kind));
      chk(int'(iss_slot) == slot, {req, " R4 slot"}, 64'(iss_slot), 64'(slot));
      chk(iss_addr == addr, {req, " R5 address"}, iss_addr, addr);
      iss_ready = 1'b1;
      tick();
      iss_ready = 1'b0;
   endtask

   task automatic expect_idle(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         tick();
         chk(!iss_valid, req, 64'(iss_valid), 64'd0);
      end
   endtask

   task automatic clear_irq();
      irq_clr = 3'b111;
      tick();
      irq_clr = '0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] base;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(!iss_valid && irq_stat == 0 && uic_cmd == 0, "R1 reset outputs",
          {iss_valid, irq_stat, uic_cmd}, 64'd0);
      chk(task_db == 0 && xfer_db == 0, "R1 reset doorbells", {task_db, xfer_db}, 64'd0);

      // R3 priority with all three sources arriving together
      task_base_hi = 32'h1; task_base_lo = 32'h1000;
      xfer_base_hi = 32'h2; xfer_base_lo = 32'h8000;
      cmd_we = 1'b1; cmd_wdata = 8'h16; task_ring = 4'b0100; xfer_ring = 8'b0000_0010;
      tick();
      cmd_we = 1'b0; task_ring = '0; xfer_ring = '0;
      expect_issue(K_UIC, 0, 64'd0, "R3 command first");
      chk(uic_cmd == 0, "R6 command cleared", 64'(uic_cmd), 64'd0);
      chk(irq_stat[0], "R6 command irq", 64'(irq_stat), 64'd1);
      expect_issue(K_TASK, 2, 64'h1_0000_1000 + 2 * TE, "R3 task second");
      expect_issue(K_XFER, 1, 64'h2_0000_8000 + 1 * XE, "R3 transfer third");
      task_done = 4'b0100; xfer_done = 8'b10;
      tick();
      task_done = '0; xfer_done = '0;
      chk(irq_stat == 3'b111, "R7 R8 irq after completions", 64'(irq_stat), 64'd7);
      clear_irq();
      chk(irq_stat == 0, "R11 write-one clear", 64'(irq_stat), 64'd0);

      // R4 R5 sweep over every transfer ring pattern
      for (int m = 1; m < (1 << XS); m++) begin
         xfer_base_lo = 32'hFFFF_FF00 + 32'(m);
         xfer_base_hi = 32'(m);
         base = {xfer_base_hi, xfer_base_lo};
         xfer_ring = XS'(m);
         tick();
         xfer_ring = '0;
         for (int s = 0; s < XS; s++)
            if (m[s]) expect_issue(K_XFER, s, base + 64'(s * XE), "R4 transfer sweep");
         expect_idle(2, "R9 no repeat after sweep");
         xfer_done = XS'(m);
         tick();
         xfer_done = '0;
         chk(xfer_db == 0, "R8 transfer doorbell emptied", 64'(xfer_db), 64'd0);
         chk(irq_stat == 3'b100, "R8 transfer irq", 64'(irq_stat), 64'd4);
         clear_irq();
      end

      // R4 R5 sweep over every task ring pattern
      for (int m = 1; m < (1 << TS); m++) begin
         task_base_lo = 32'hFFFF_FFF0 - 32'(m);
         task_base_hi = 32'(m) << 4;
         base = {task_base_hi, task_base_lo};
         task_ring = TS'(m);
         tick();
         task_ring = '0;
         for (int s = 0; s < TS; s++)
            if (m[s]) expect_issue(K_TASK, s, base + 64'(s * TE), "R4 task sweep");
         expect_idle(2, "R9 no task repeat");
         task_done = TS'(m);
         tick();
         task_done = '0;
         chk(task_db == 0, "R7 task doorbell emptied", 64'(task_db), 64'd0);
         chk(irq_stat == 3'b010, "R7 task irq", 64'(irq_stat), 64'd2);
         clear_irq();
      end

      // R7 single task completion clears only its own bit
      task_ring = 4'b0011;
      tick();
      task_ring = '0;
      expect_issue(K_TASK, 0, {task_base_hi, task_base_lo}, "R7 setup");
      expect_issue(K_TASK, 1, {task_base_hi, task_base_lo} + TE, "R7 setup");
      task_done = 4'b0001;
      tick();
      task_done = '0;
      chk(task_db == 4'b0010, "R7 only slot 0 cleared", 64'(task_db), 64'd2);
      chk(irq_stat[1], "R7 irq bit1", 64'(irq_stat), 64'd2);
      task_done = 4'b0010;
      tick();
      task_done = '0;
      clear_irq();

      // R10 hold while ready is low, command arriving meanwhile
      xfer_ring = 8'b0010_0000;
      tick();
      xfer_ring = '0;
      tick(); tick();
      cmd_we = 1'b1; cmd_wdata = 8'h05;
      tick();
      cmd_we = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk(iss_valid && iss_kind == K_XFER && iss_slot == 3'd5, "R10 held issue stable",
             {iss_valid, iss_kind, 5'(iss_slot)}, {1'b1, K_XFER, 5'd5});
         tick();
      end
      iss_ready = 1'b1;
      tick();
      iss_ready = 1'b0;
      chk(!iss_valid, "R10 gap after accept", 64'(iss_valid), 64'd0);
      expect_issue(K_UIC, 0, 64'd0, "R10 command after hold");
      xfer_done = 8'b0010_0000;
      tick();
      xfer_done = '0;
      clear_irq();

      // R9 re-ring of an outstanding slot, then after completion
      xfer_ring = 8'b1;
      tick();
      xfer_ring = '0;
      expect_issue(K_XFER, 0, {xfer_base_hi, xfer_base_lo}, "R9 first ring");
      xfer_ring = 8'b1;
      tick();
      xfer_ring = '0;
      expect_idle(4, "R9 outstanding slot not reissued");
      xfer_done = 8'b1;
      tick();
      xfer_done = '0;
      xfer_ring = 8'b1;
      tick();
      xfer_ring = '0;
      expect_issue(K_XFER, 0, {xfer_base_hi, xfer_base_lo}, "R9 reissue after done");

      // R8 rung-but-unpicked slot dropped by a transfer completion
      cmd_we = 1'b1; cmd_wdata = 8'h01;
      tick();
      cmd_we = 1'b0;
      tick(); tick();
      chk(iss_valid && iss_kind == K_UIC, "R8 command held", 64'(iss_kind), 64'(K_UIC));
      xfer_ring = 8'b10;
      tick();
      xfer_ring = '0;
      chk(xfer_db == 8'b11, "R8 ring landed", 64'(xfer_db), 64'd3);
      xfer_done = 8'b1;
      irq_clr = 3'b100;
      tick();
      xfer_done = '0;
      irq_clr = '0;
      chk(xfer_db == 0, "R8 untracked ring dropped", 64'(xfer_db), 64'd0);
      chk(irq_stat[2], "R11 set wins over clear", 64'(irq_stat), 64'd4);
      iss_ready = 1'b1;
      tick();
      iss_ready = 1'b0;
      expect_idle(4, "R8 dropped slot never issued");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule